// File: doc/BRIEF.md
# Loadable Clearable Ripple-Carry Up Counter

This block is a synchronous up-counter of parameterised width. It is organised the way a lookup-table logic cell would build it. Each bit position produces two results. One is its next sum bit. The other is a separate carry bit that ripples to the next position, starting from the count enable at bit zero. A two-way selector then chooses between the incremented value and a parallel word supplied on the load port. A synchronous active-high clear gates the selector output to zero, and the result is registered on the rising clock edge.

There is no direction control: the counter only ever increments. The clear input takes the slot that a cascade input would otherwise occupy. The counter has no asynchronous reset, so the clear input is also how the count is brought to a known value after power-up. The carry output tells a following stage that this slice is about to roll over, so slices can be chained into a wider counter.

Top module: `ld_clr_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, `q` becomes all zeros after that edge, whatever `ld`, `en` and `ld_data` are.
- R2: When `ld` is high and `clr` is low at a rising clock edge, `q` takes the value of `ld_data` after that edge, whether `en` is high or low.
- R3: When `en` is high and both `ld` and `clr` are low at a rising clock edge, `q` becomes its previous value plus one, modulo 2^WIDTH. All ones therefore wraps to all zeros.
- R4: When `en`, `ld` and `clr` are all low at a rising clock edge, `q` keeps its value.
- R5: `carry_out` is combinational. It is 1 exactly when `en` is 1 and every bit of `q` is 1, and it is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for every state change |
| en | input | 1 | Count enable; it feeds the carry chain at bit zero |
| ld | input | 1 | Synchronous parallel load request |
| clr | input | 1 | Synchronous clear; it overrides load and count |
| ld_data | input | WIDTH | Parallel load word |
| q | output | WIDTH | Registered count |
| carry_out | output | 1 | Carry leaving the top bit, for the next stage |

## Verification
The hardest case to reach is a carry that travels the whole chain. It needs every bit at one while the enable is high, and counting up from zero would take 2^WIDTH cycles to get there. The stimulus reaches it at once by loading all ones or a value just below all ones, then counting across the wrap. It also holds at all ones with the enable low, to show that the carry stays low in that case. Further runs of random control mixes compare every clock against a behavioural model, so the clear-over-load and load-over-count orderings are met many times.

// File: rtl/ld_clr_counter.sv
module ld_clr_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             en,
  input  logic             ld,
  input  logic             clr,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] picked;
  logic [WIDTH-1:0] nxt;

  assign chain[0] = en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]     = q[i] ^ chain[i];
    assign chain[i+1] = q[i] & chain[i];
  end

  assign picked    = ld ? ld_data : sum;
  assign nxt       = picked & {WIDTH{~clr}};
  assign carry_out = chain[WIDTH];

  always_ff @(posedge clk) q <= nxt;

endmodule

// File: rtl/ld_clr_counter_chk.sv
module ld_clr_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             en,
  input logic             ld,
  input logic             clr,
  input logic [WIDTH-1:0] ld_data,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (q == '0));

  p_load_word_r2: assert property (@(posedge clk) disable iff (!armed)
    (ld && !clr) |=> (q == $past(ld_data)));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!armed)
    (en && !ld && !clr) |=> (q == WIDTH'($past(q) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (!en && !ld && !clr) |=> $stable(q));

  p_carry_full_r5: assert property (@(posedge clk) disable iff (!armed)
    carry_out == (en && (q == {WIDTH{1'b1}})));

endmodule

bind ld_clr_counter ld_clr_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .en(en), .ld(ld), .clr(clr),
  .ld_data(ld_data), .q(q), .carry_out(carry_out)
);

// File: tb/sim_ld_clr_counter.sv
`timescale 1ns/1ps
module sim_ld_clr_counter;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic en = 1'b0, ld = 1'b0, clr = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] q;
  logic carry_out;

  int total = 0;
  int bad = 0;
  logic [W-1:0] model;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ld_clr_counter #(.WIDTH(W)) u0 (
    .clk(clk), .en(en), .ld(ld), .clr(clr),
    .ld_data(ld_data), .q(q), .carry_out(carry_out)
  );

  task automatic step(input logic e, input logic l, input logic c, input logic [W-1:0] d);
    string tag;
    logic exp_c;
    @(negedge clk);
    en = e; ld = l; clr = c; ld_data = d;
    #1;
    exp_c = e && (model == ONES);
    total++;
    if (carry_out !== exp_c) begin
      bad++;
      $display("FAIL R5 carry_out=%b expected=%b", carry_out, exp_c);
    end
    if (c) begin model = '0; tag = "R1"; end
    else if (l) begin model = d; tag = "R2"; end
    else if (e) begin model = W'(model + 1'b1); tag = "R3"; end
    else tag = "R4";
    @(posedge clk);
    #1;
    total++;
    if (q !== model) begin
      bad++;
      $display("FAIL %s q=%h expected=%h", tag, q, model);
    end
  endtask

  initial begin
    model = 'x;
    step(1, 1, 1, 8'hA5);            // R1 clear wins over load and count
    step(0, 0, 0, 8'h00);            // R4 hold
    step(1, 1, 0, 8'hFD);            // R2 load wins over count
    for (int i = 0; i < 4; i++) step(1, 0, 0, 8'h00); // R3 count across the wrap, R5 carry
    step(0, 1, 0, ONES);             // R2 load all ones
    step(0, 0, 0, 8'h00);            // R5 all ones but enable low: no carry
    step(1, 0, 0, 8'h00);            // R5 carry high, R3 wrap to zero
    step(1, 1, 0, 8'h3C);
    step(1, 0, 1, 8'h77);            // R1 clear over count
    for (int i = 0; i < 600; i++) begin
      logic [2:0] r;
      r = 3'($urandom);
      step(r[0] | r[2], r[1] & ~r[2], ($urandom % 13) == 0, W'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule